// File: doc/BRIEF.md
# ADC Ping-Pong Sample Writer with Status Register

This block takes the sample stream of one ADC channel and stores it in system SRAM through a small FIFO and a single write port. It alternates between two buffers, A and B. Each buffer has its own base address and length in samples. When the buffer in use has received its last sample, the block marks that buffer full and continues at the base of the other buffer. Software can therefore process one half while the hardware fills the other.

A single 32-bit control and status word sits on a simple register bus. It holds the enable, two interrupt enables and a count-table enable, all writable. It also holds three hardware flags: buffer A full, buffer B full, and a FIFO overflow error. Reading the word clears these flags. When the FIFO is already full and a new sample arrives, the newest unread entry is overwritten by the new sample and the error flag is raised. When the count-table enable is set, each sample write is followed by a second write that stores the running sample count of that buffer into a two-entry table. The interrupt output is a level.

Top module: `adc_pingpong_dma`

## Requirements
- R1: After reset, `reg_rdata` reads 0, `irq` is 0 and `mem_req` is 0.
- R2: A register write loads bit 31 (run enable), bit 24 (buffer B interrupt enable), bit 15 (count-table enable) and bit 8 (buffer A interrupt enable) from `reg_wdata`. Bits 23, 16 and 0 cannot be written. All other bits read 0. The new value is visible on the cycle after the write.
- R3: While bit 31 reads 0, samples are dropped and `mem_req` stays 0. On every clock edge in that state the FIFO is emptied and write generation returns to buffer A, index 0, with no count write pending.
- R4: Sample k of a buffer (k counting from 0) is written to that buffer's base address plus k. After `buf_a_len` writes to A, writing moves to `buf_b_base`. After `buf_b_len` writes to B, writing returns to `buf_a_base`.
- R5: The acknowledged write of a buffer's last sample sets that buffer's full flag: bit 0 for A, bit 16 for B. The flag reads 1 from the next cycle.
- R6: A cycle with `reg_rd` high returns the current word. At the next edge, bits 0, 16 and 23 clear, except for a flag that hardware sets in that same cycle, which reads 1 afterwards.
- R7: A sample that arrives while the FIFO holds DEPTH entries, and no entry leaves in that cycle, replaces the most recently stored unread entry and sets bit 23.
- R8: With bit 15 set, each acknowledged sample write is followed by a count write to `cnt_tbl_base` + 0 (buffer A) or + 1 (buffer B). Its data is the number of samples written into that buffer so far, including the one just written. The next sample write waits until the count write is acknowledged.
- R9: `irq` equals (bit 0 AND bit 8) OR (bit 16 AND bit 24).
- R10: `mem_req` stays high, with `mem_addr` and `mem_wdata` stable, until a cycle with `mem_ack` high. Each such cycle completes exactly one write.
- R11: Samples reach `mem_wdata` in the order they arrived, apart from entries overwritten under R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read-clear side effect) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current register value |
| buf_a_base | input | AW | Buffer A base word address |
| buf_b_base | input | AW | Buffer B base word address |
| buf_a_len | input | CW | Buffer A length in samples (at least 1) |
| buf_b_len | input | CW | Buffer B length in samples (at least 1) |
| cnt_tbl_base | input | AW | Count table base address |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | DW | Sample value |
| mem_req | output | 1 | SRAM write request |
| mem_addr | output | AW | SRAM write address |
| mem_wdata | output | DW | SRAM write data |
| mem_ack | input | 1 | SRAM write accepted this cycle |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that buffer lengths and base addresses do not change while the block is enabled, and that `mem_ack` has no meaning while `mem_req` is low. The read-clear and error-clear properties are conditioned on there being no acknowledged write or no incoming sample in the read cycle, so they never count a legitimate same-cycle set as a failure. The stimulus sets up the configuration once, before enabling the block, and keeps every length at least 1. It varies the acknowledge pattern, sample arrival and read strobes freely, including reads that land on the cycle of a flag set.

// File: rtl/adc_dma_pkg.sv
// Package: shared constants and types for the ping-pong sample writer.
// Holds the bit positions of the control/status word and the write state type.
package adc_dma_pkg;

    // Control/status word bit positions (software decodes these)
    localparam int BIT_RUN     = 31;
    localparam int BIT_IEN_B   = 24;
    localparam int BIT_OVF     = 23;
    localparam int BIT_FULL_B  = 16;
    localparam int BIT_CNT_EN  = 15;
    localparam int BIT_IEN_A   = 8;
    localparam int BIT_FULL_A  = 0;

    // Number of hardware status flags
    localparam int NUM_FLAGS   = 3;
    localparam int FLG_A       = 0;
    localparam int FLG_B       = 1;
    localparam int FLG_OVF     = 2;

    // Write engine phase: sample write or trailing count write
    typedef enum logic {
        ST_SAMPLE = 1'b0,
        ST_COUNT  = 1'b1
    } wr_state_t;

endpackage

// File: rtl/adc_dma_flag.sv
// Module: sticky status flag.
// Set by a hardware event and cleared by a software read strobe.
// If a set and a clear arrive in the same cycle, the set wins.
// Assumes: synchronous active-low reset.
module adc_dma_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic rd_clr,
    output logic q
);

    // Flag state: a set overrides a read-clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (set) begin
            q <= 1'b1;
        end else if (rd_clr) begin
            q <= 1'b0;
        end
    end

endmodule

// File: rtl/adc_dma_regs.sv
// Module: control/status word and interrupt generation.
// Holds the four software-writable control bits and the three read-clear
// hardware flags, assembles the read value and drives the level interrupt.
// Assumes: set_* inputs are single-cycle hardware events.
module adc_dma_regs
    import adc_dma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    input  logic        set_full_a,
    input  logic        set_full_b,
    input  logic        set_ovf,
    output logic [31:0] reg_rdata,
    output logic        run,
    output logic        cnt_en,
    output logic        irq
);

    logic                 ien_a_q;
    logic                 ien_b_q;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_q;
    logic                 unused_wbits;

    assign unused_wbits = ^reg_wdata;

    // Control bits: loaded as a group on every register write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            ien_a_q <= 1'b0;
            ien_b_q <= 1'b0;
            cnt_en  <= 1'b0;
        end else if (reg_wr) begin
            run     <= reg_wdata[BIT_RUN];
            ien_a_q <= reg_wdata[BIT_IEN_A];
            ien_b_q <= reg_wdata[BIT_IEN_B];
            cnt_en  <= reg_wdata[BIT_CNT_EN];
        end
    end

    // Gather the hardware set events in flag order
    always_comb begin
        flag_set          = '0;
        flag_set[FLG_A]   = set_full_a;
        flag_set[FLG_B]   = set_full_b;
        flag_set[FLG_OVF] = set_ovf;
    end

    // One sticky read-clear cell per hardware flag
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        adc_dma_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set    (flag_set[i]),
            .rd_clr (reg_rd),
            .q      (flag_q[i])
        );
    end

    // Read value: fixed bit positions, unused bits zero
    always_comb begin
        reg_rdata             = '0;
        reg_rdata[BIT_RUN]    = run;
        reg_rdata[BIT_IEN_B]  = ien_b_q;
        reg_rdata[BIT_OVF]    = flag_q[FLG_OVF];
        reg_rdata[BIT_FULL_B] = flag_q[FLG_B];
        reg_rdata[BIT_CNT_EN] = cnt_en;
        reg_rdata[BIT_IEN_A]  = ien_a_q;
        reg_rdata[BIT_FULL_A] = flag_q[FLG_A];
    end

    // Level interrupt from enabled full flags
    assign irq = (flag_q[FLG_A] & ien_a_q) | (flag_q[FLG_B] & ien_b_q);

endmodule

// File: rtl/adc_dma_fifo.sv
// Module: sample FIFO with overwrite-on-full.
// A push into a full FIFO with no pop in the same cycle replaces the newest
// stored entry and pulses ovf_evt. The clr input empties it synchronously.
// Assumes: DEPTH >= 2, so the newest entry is never the one being read out.
module adc_dma_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full,
    output logic          ovf_evt
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = PW + 1;
    localparam logic [PW-1:0]   LAST_PTR = PW'(DEPTH - 1);
    localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

    logic [DW-1:0]   store [DEPTH];
    logic [PW-1:0]   wr_ptr;
    logic [PW-1:0]   rd_ptr;
    logic [PW-1:0]   wr_prev;
    logic [CNTW-1:0] used;
    logic            overwrite;
    logic            do_append;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PW'(1);
    endfunction

    assign empty     = (used == '0);
    assign full      = (used == FULL_CNT);
    assign overwrite = push && full && !pop;
    assign do_append = push && !overwrite;
    assign ovf_evt   = overwrite && !clr;
    assign wr_prev   = (wr_ptr == '0) ? LAST_PTR : wr_ptr - PW'(1);
    assign dout      = store[rd_ptr];

    // Storage write: append at the tail, or replace the newest entry when full
    always_ff @(posedge clk) begin
        if (push && !clr) begin
            store[overwrite ? wr_prev : wr_ptr] <= din;
        end
    end

    // Pointers and fill level: cleared by reset or by the clr hold
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            used   <= '0;
        end else begin
            if (do_append) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            case ({do_append, pop})
                2'b10:   used <= used + CNTW'(1);
                2'b01:   used <= used - CNTW'(1);
                default: used <= used;
            endcase
        end
    end

endmodule

// File: rtl/adc_dma_writer.sv
// Module: ping-pong SRAM write generator.
// Issues one sample write per FIFO entry at base+index of the active buffer,
// swaps buffers when the active one reaches its length, and optionally follows
// each sample write with a count-table write. Held in reset while run is 0.
// Assumes: lengths are at least 1 and stay constant while run is 1.
module adc_dma_writer
    import adc_dma_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          cnt_en,
    input  logic [AW-1:0] a_base,
    input  logic [AW-1:0] b_base,
    input  logic [CW-1:0] a_len,
    input  logic [CW-1:0] b_len,
    input  logic [AW-1:0] cnt_base,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_dout,
    input  logic          mem_ack,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          pop,
    output logic          full_a_evt,
    output logic          full_b_evt
);

    wr_state_t     state_q;
    logic          cur_b_q;
    logic [CW-1:0] idx_q;
    logic          cnt_b_q;
    logic [CW-1:0] cnt_val_q;

    logic          in_count;
    logic          xfer;
    logic [CW-1:0] cur_len;
    logic [AW-1:0] cur_base;
    logic [CW-1:0] idx_inc;
    logic          at_last;

    // Request, address and data selection for the current phase
    always_comb begin
        in_count  = (state_q == ST_COUNT);
        mem_req   = run && (in_count || !fifo_empty);
        xfer      = mem_req && mem_ack;
        pop       = xfer && !in_count;
        cur_len   = cur_b_q ? b_len : a_len;
        cur_base  = cur_b_q ? b_base : a_base;
        idx_inc   = idx_q + CW'(1);
        at_last   = (idx_inc == cur_len);
        mem_addr  = in_count ? (cnt_base + AW'(cnt_b_q)) : (cur_base + AW'(idx_q));
        mem_wdata = in_count ? DW'(cnt_val_q) : fifo_dout;
        full_a_evt = pop && at_last && !cur_b_q;
        full_b_evt = pop && at_last && cur_b_q;
    end

    // Buffer position, buffer swap and count-write sequencing
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            state_q   <= ST_SAMPLE;
            cur_b_q   <= 1'b0;
            idx_q     <= '0;
            cnt_b_q   <= 1'b0;
            cnt_val_q <= '0;
        end else if (pop) begin
            if (at_last) begin
                cur_b_q <= ~cur_b_q;
                idx_q   <= '0;
            end else begin
                idx_q   <= idx_inc;
            end
            if (cnt_en) begin
                state_q   <= ST_COUNT;
                cnt_b_q   <= cur_b_q;
                cnt_val_q <= idx_inc;
            end
        end else if (xfer) begin
            state_q <= ST_SAMPLE;
        end
    end

endmodule

// File: rtl/adc_pingpong_dma.sv
// Module: ADC ping-pong sample writer, top level.
// Connects the control/status word, the overwrite FIFO and the SRAM write
// generator. Samples enter the FIFO only while the run bit is 1.
// Assumes: one channel, one SRAM write port with single-cycle acknowledge.
module adc_pingpong_dma #(
    parameter int AW    = 12,
    parameter int DW    = 16,
    parameter int CW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic [AW-1:0] buf_a_base,
    input  logic [AW-1:0] buf_b_base,
    input  logic [CW-1:0] buf_a_len,
    input  logic [CW-1:0] buf_b_len,
    input  logic [AW-1:0] cnt_tbl_base,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    output logic          irq
);

    logic          run;
    logic          cnt_en;
    logic          fifo_push;
    logic          fifo_pop;
    logic          fifo_empty;
    logic          fifo_full;
    logic          fifo_ovf;
    logic [DW-1:0] fifo_dout;
    logic          full_a_evt;
    logic          full_b_evt;

    // Samples are only accepted while running
    assign fifo_push = smp_valid && run;

    adc_dma_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .set_full_a (full_a_evt),
        .set_full_b (full_b_evt),
        .set_ovf    (fifo_ovf),
        .reg_rdata  (reg_rdata),
        .run        (run),
        .cnt_en     (cnt_en),
        .irq        (irq)
    );

    adc_dma_fifo #(
        .DW    (DW),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!run),
        .push    (fifo_push),
        .pop     (fifo_pop),
        .din     (smp_data),
        .dout    (fifo_dout),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .ovf_evt (fifo_ovf)
    );

    adc_dma_writer #(
        .AW (AW),
        .DW (DW),
        .CW (CW)
    ) u_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .cnt_en     (cnt_en),
        .a_base     (buf_a_base),
        .b_base     (buf_b_base),
        .a_len      (buf_a_len),
        .b_len      (buf_b_len),
        .cnt_base   (cnt_tbl_base),
        .fifo_empty (fifo_empty),
        .fifo_dout  (fifo_dout),
        .mem_ack    (mem_ack),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .pop        (fifo_pop),
        .full_a_evt (full_a_evt),
        .full_b_evt (full_b_evt)
    );

endmodule

// File: rtl/adc_dma_checker.sv
// Module: protocol and status checker for adc_pingpong_dma, bound to the top.
// Observes only top-level ports.
module adc_dma_checker #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_rd,
    input logic          smp_valid,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic [31:0]   reg_rdata,
    input logic          irq
);

    // R3: nothing is requested while the run bit reads 0
    assert_off_no_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[31] |-> !mem_req);

    // R10: an unacknowledged request holds address and data
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && reg_rdata[31]) |=>
        (!reg_rdata[31] || (mem_req && $stable(mem_addr) && $stable(mem_wdata))));

    // R5: a full flag only rises after an acknowledged write
    assert_full_a_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[0]) |-> $past(mem_req && mem_ack));

    assert_full_b_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[16]) |-> $past(mem_req && mem_ack));

    // R6: a read with no write completing clears both full flags
    assert_rd_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !(mem_req && mem_ack)) |=> (!reg_rdata[0] && !reg_rdata[16]));

    // R7: a read with no incoming sample clears the error flag
    assert_ovf_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !smp_valid) |=> !reg_rdata[23]);

    // R9: interrupt only with an enabled, set flag
    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[8] && !reg_rdata[24]) |-> !irq);

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (reg_rdata[0] || reg_rdata[16]));

endmodule

bind adc_pingpong_dma adc_dma_checker #(
    .AW (AW),
    .DW (DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .smp_valid (smp_valid),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
);

// File: tb/adc_pingpong_dma_bench.sv
// Bench: behavioural per-cycle reference model compared on every clock.
module adc_pingpong_dma_bench;

    localparam int AW = 12;
    localparam int DW = 16;
    localparam int CW = 8;
    localparam int DEPTH = 4;
    localparam int A_BASE = 12'h100;
    localparam int B_BASE = 12'h200;
    localparam int C_BASE = 12'h300;
    localparam int A_LEN = 3;
    localparam int B_LEN = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    adc_pingpong_dma #(.AW(AW), .DW(DW), .CW(CW), .DEPTH(DEPTH)) u_adc_pingpong_dma (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .buf_a_base(AW'(A_BASE)), .buf_b_base(AW'(B_BASE)),
        .buf_a_len(CW'(A_LEN)), .buf_b_len(CW'(B_LEN)),
        .cnt_tbl_base(AW'(C_BASE)), .smp_valid(smp_valid), .smp_data(smp_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .irq(irq)
    );

    // Reference model state
    bit m_run, m_iea, m_ieb, m_cen, m_fa, m_fb, m_ovf;
    int q[$];
    bit m_cur, m_cp, m_cbuf;
    int m_idx, m_cval;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_word();
        logic [31:0] w = '0;
        w[31] = m_run; w[24] = m_ieb; w[23] = m_ovf; w[16] = m_fb;
        w[15] = m_cen; w[8] = m_iea; w[0] = m_fa;
        return w;
    endfunction

    // Compare outputs, advance the model, then advance one clock
    task automatic cycle();
        bit req;
        int e_addr, e_wd;
        bit sa, sb, so;
        #2;
        req = m_run && (m_cp || q.size() > 0);
        chk(mem_req === req, "R10 mem_req", 32'(mem_req), 32'(req));
        if (req) begin
            e_addr = m_cp ? C_BASE + m_cbuf : (m_cur ? B_BASE : A_BASE) + m_idx;
            e_wd = m_cp ? m_cval : q[0];
            chk(mem_addr === AW'(e_addr), m_cp ? "R8 count addr" : "R4 sample addr",
                32'(mem_addr), 32'(e_addr));
            chk(mem_wdata === DW'(e_wd), m_cp ? "R8 count data" : "R11 sample data",
                32'(mem_wdata), 32'(e_wd));
        end
        chk(reg_rdata === m_word(), "R5 status word", reg_rdata, m_word());
        chk(irq === ((m_fa && m_iea) || (m_fb && m_ieb)), "R9 irq level", 32'(irq),
            32'((m_fa && m_iea) || (m_fb && m_ieb)));
        sa = 0; sb = 0; so = 0;
        if (m_run) begin
            if (req && mem_ack) begin
                if (m_cp) begin
                    m_cp = 0;
                end else begin
                    void'(q.pop_front());
                    if (m_cen) begin
                        m_cp = 1; m_cbuf = m_cur; m_cval = m_idx + 1;
                    end
                    if (m_idx + 1 == (m_cur ? B_LEN : A_LEN)) begin
                        if (m_cur) sb = 1; else sa = 1;
                        m_cur = !m_cur; m_idx = 0;
                    end else begin
                        m_idx++;
                    end
                end
            end
            if (smp_valid) begin
                if (q.size() == DEPTH) begin
                    q[q.size()-1] = int'(smp_data);
                    so = 1;
                end else begin
                    q.push_back(int'(smp_data));
                end
            end
        end else begin
            q.delete(); m_cur = 0; m_idx = 0; m_cp = 0;
        end
        m_fa  = (reg_rd ? 1'b0 : m_fa) | sa;
        m_fb  = (reg_rd ? 1'b0 : m_fb) | sb;
        m_ovf = (reg_rd ? 1'b0 : m_ovf) | so;
        if (reg_wr) begin
            m_run = reg_wdata[31]; m_ieb = reg_wdata[24];
            m_cen = reg_wdata[15]; m_iea = reg_wdata[8];
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input bit wr, input bit rd, input logic [31:0] wd,
                         input bit v, input bit ack);
        reg_wr = wr; reg_rd = rd; reg_wdata = wd; smp_valid = v; mem_ack = ack;
        smp_data = DW'($urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(reg_rdata === 32'h0, "R1 rdata", reg_rdata, 32'h0);
        chk(irq === 1'b0, "R1 irq", 32'(irq), 32'h0);
        chk(mem_req === 1'b0, "R1 mem_req", 32'(mem_req), 32'h0);
        rst_n = 1'b1;

        // R2: writable bits only
        drive(1, 0, 32'hFFFF_FFFF, 0, 0); cycle();
        chk(reg_rdata === 32'h8100_8100, "R2 write all ones", reg_rdata, 32'h8100_8100);
        drive(1, 0, 32'h0, 0, 0); cycle();
        chk(reg_rdata === 32'h0, "R2 write zero", reg_rdata, 32'h0);

        // R4/R5: run with both interrupts, steady acknowledge
        drive(1, 0, 32'h8100_0100, 0, 0); cycle();
        for (int i = 0; i < 24; i++) begin
            drive(0, 0, 0, i[0], 1); cycle();
        end
        chk(reg_rdata[0] === 1'b1 && reg_rdata[16] === 1'b1, "R5 both full", reg_rdata, 32'h0001_0001);
        chk(irq === 1'b1, "R9 irq set", 32'(irq), 32'h1);
        drive(0, 1, 0, 0, 0); cycle();
        chk(reg_rdata[16] === 1'b0 && reg_rdata[0] === 1'b0, "R6 read clears", reg_rdata, 32'h8100_0100);
        chk(irq === 1'b0, "R9 irq after clear", 32'(irq), 32'h0);

        // R7: overflow with stalled memory
        for (int i = 0; i < 8; i++) begin
            drive(0, 0, 0, 1, 0); cycle();
        end
        chk(reg_rdata[23] === 1'b1, "R7 overflow set", reg_rdata, 32'h0080_0000);
        for (int i = 0; i < 10; i++) begin
            drive(0, 0, 0, 0, 1); cycle();
        end
        drive(0, 1, 0, 0, 0); cycle();
        chk(reg_rdata[23] === 1'b0, "R7 overflow cleared", reg_rdata, 32'h0);

        // R8/R6: count table, irregular acknowledge, sample and read pattern
        drive(1, 0, 32'h8100_8100, 0, 0); cycle();
        for (int i = 0; i < 400; i++) begin
            drive(0, ($urandom % 8) == 0, 0, ($urandom % 3) != 0, ($urandom % 4) != 0);
            cycle();
        end

        // R3: disable with a loaded FIFO
        for (int i = 0; i < 3; i++) begin
            drive(0, 0, 0, 1, 0); cycle();
        end
        drive(1, 0, 32'h0, 0, 0); cycle();
        chk(mem_req === 1'b0, "R3 no request when off", 32'(mem_req), 32'h0);
        for (int i = 0; i < 3; i++) begin
            drive(0, 0, 0, 1, 1); cycle();
            chk(mem_req === 1'b0, "R3 samples ignored when off", 32'(mem_req), 32'h0);
        end
        drive(1, 0, 32'h8000_0000, 0, 0); cycle();
        chk(mem_req === 1'b0, "R3 FIFO emptied", 32'(mem_req), 32'h0);
        drive(0, 0, 0, 1, 0); cycle();
        chk(mem_req === 1'b1 && mem_addr === AW'(A_BASE), "R3 restart at buffer A",
            32'(mem_addr), 32'(A_BASE));

        // R9: flag without enable gives no interrupt
        drive(0, 1, 0, 0, 0); cycle();
        for (int i = 0; i < 6; i++) begin
            drive(0, 0, 0, i < 3, 1); cycle();
        end
        chk(reg_rdata[0] === 1'b1 && irq === 1'b0, "R9 masked flag", {reg_rdata[31:1], irq}, 32'h8000_0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule